// File: doc/BRIEF.md
# Mailbox Command Dispatcher

This block sequences a doorbell-driven command mailbox in a memory-expansion device. The host loads a 32-bit command word that holds a command number, a command-set number and an input payload length. It then rings a doorbell. The dispatcher joins set and command into a 16-bit opcode. It looks the opcode up in a fixed table of supported commands and compares the supplied length with the length that command expects.

A rejected command is answered at once with an error code. An accepted command starts an external handler with a one-cycle start pulse, and the dispatcher waits for the handler's done pulse, which carries a return code and an output length. On completion the dispatcher does three things, in this order:

1. It rewrites the status word.
2. It rewrites the command word with zeroed set and command fields and the output length.
3. One cycle later, it drops the doorbell so the host knows the result is ready.

Top module: `mbox_dispatch`

## Requirements
- R1: The opcode is `{set, command}`, where set = `cmd_wdata[15:8]` is the upper byte and command = `cmd_wdata[7:0]` is the lower byte; the length is `cmd_wdata[31:16]`. An accepted command raises `hnd_start` with `hnd_op` equal to that opcode and `hnd_len` equal to the supplied length.
- R2: Supported opcodes and their expected input lengths:
  - 0x0100: length 1
  - 0x0102: length 0
  - 0x0103: length 4
  - 0x0200: length 0
  - 0x0300: length 0
  - 0x0301: length 8
  - 0x0400: length 0
  - 0x0401: length 0x18
  - 0x4000: length 0
  - 0x4100: length 0
  - 0x4102: length 8
- R3: An opcode outside the table completes with return code 0x03 and no handler start.
- R4: A table opcode whose supplied length differs from its expected length completes with return code 0x16 and no handler start.
- R5: Opcodes 0x0101 and 0x4103 accept any length and always start the handler.
- R6: On completion:
  - `sts_reg` is rewritten from zero, with only the return code in bits [7:0].
  - `cmd_reg[15:0]` reads zero.
  - `cmd_reg[31:16]` holds the handler's output length, or the supplied length when no handler ran.
  - A handler's return code is passed through unchanged.
- R7: `doorbell` falls exactly one cycle after `sts_reg` and `cmd_reg` take their completion values.
- R8: While `doorbell` is high, both `cmd_wr` and `db_set` are ignored: the command word is unchanged and no second command starts.
- R9: An output length above PAYLOAD_BYTES is clamped to PAYLOAD_BYTES and reported with return code 0x04. A length equal to PAYLOAD_BYTES passes unchanged.
- R10: `hnd_start` lasts one cycle, and `hnd_done` is ignored unless a handler is running.
- R11: After reset, `doorbell`, `hnd_start`, `cmd_reg` and `sts_reg` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Host write strobe for the command word |
| cmd_wdata | input | 32 | Command word: [7:0] command, [15:8] set, [31:16] length |
| db_set | input | 1 | Host request to ring the doorbell |
| doorbell | output | 1 | Doorbell, high while a command is in progress |
| cmd_reg | output | 32 | Command word as seen by the host |
| sts_reg | output | 16 | Status word, return code in [7:0] |
| hnd_start | output | 1 | One-cycle handler start pulse |
| hnd_op | output | 16 | Opcode presented to the handler |
| hnd_len | output | 16 | Input length presented to the handler |
| hnd_done | input | 1 | Handler completion pulse |
| hnd_rc | input | 8 | Handler return code, valid with hnd_done |
| hnd_olen | input | 16 | Handler output length, valid with hnd_done |

## Verification
A wrong table entry or a wrong length comparison shows up on the first command that reaches that opcode. It appears within a few cycles of the doorbell as the wrong return code, together with a start pulse that is missing or unexpected. A dispatcher stuck in its wait state shows up as a doorbell that never drops. A wrongly ordered write-back shows up as a status word that changes in the same cycle the doorbell falls. The sweep covers every table opcode, its neighbours and several lengths, so a single wrong entry is exposed directly at the ports.

// File: rtl/mbox_dispatch.sv
module mbox_dispatch #(
  parameter int PAYLOAD_BYTES = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  input  logic        db_set,
  output logic        doorbell,
  output logic [31:0] cmd_reg,
  output logic [15:0] sts_reg,
  output logic        hnd_start,
  output logic [15:0] hnd_op,
  output logic [15:0] hnd_len,
  input  logic        hnd_done,
  input  logic [7:0]  hnd_rc,
  input  logic [15:0] hnd_olen
);

  localparam logic [15:0] PL_MAX     = 16'(PAYLOAD_BYTES);
  localparam logic [7:0]  RC_BADIN   = 8'h02;
  localparam logic [7:0]  RC_UNSUP   = 8'h03;
  localparam logic [7:0]  RC_INTERR  = 8'h04;
  localparam logic [7:0]  RC_BADLEN  = 8'h16;

  typedef enum logic [1:0] {S_IDLE, S_DECODE, S_BUSY, S_FIN} state_t;
  state_t state_q;

  logic        known, any_len;
  logic [15:0] exp_len;
  logic        len_ok, over;

  assign hnd_op  = cmd_reg[15:0];
  assign hnd_len = cmd_reg[31:16];

  always_comb begin
    known   = 1'b1;
    any_len = 1'b0;
    exp_len = 16'd0;
    case (hnd_op)
      16'h0100: exp_len = 16'd1;
      16'h0101: any_len = 1'b1;
      16'h0102: exp_len = 16'd0;
      16'h0103: exp_len = 16'd4;
      16'h0200: exp_len = 16'd0;
      16'h0300: exp_len = 16'd0;
      16'h0301: exp_len = 16'd8;
      16'h0400: exp_len = 16'd0;
      16'h0401: exp_len = 16'h18;
      16'h4000: exp_len = 16'd0;
      16'h4100: exp_len = 16'd0;
      16'h4102: exp_len = 16'd8;
      16'h4103: any_len = 1'b1;
      default:  known   = 1'b0;
    endcase
  end

  assign len_ok = any_len || (hnd_len == exp_len);
  assign over   = hnd_olen > PL_MAX;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      doorbell  <= 1'b0;
      cmd_reg   <= '0;
      sts_reg   <= '0;
      hnd_start <= 1'b0;
    end else begin
      hnd_start <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (cmd_wr) cmd_reg <= cmd_wdata;
          if (db_set) begin
            doorbell <= 1'b1;
            state_q  <= S_DECODE;
          end
        end
        S_DECODE: begin
          if (!known) begin
            sts_reg <= {8'h00, RC_UNSUP};
            cmd_reg <= {hnd_len, 16'h0000};
            state_q <= S_FIN;
          end else if (!len_ok) begin
            sts_reg <= {8'h00, RC_BADLEN};
            cmd_reg <= {hnd_len, 16'h0000};
            state_q <= S_FIN;
          end else begin
            hnd_start <= 1'b1;
            state_q   <= S_BUSY;
          end
        end
        S_BUSY: begin
          if (hnd_done) begin
            sts_reg <= {8'h00, over ? RC_INTERR : hnd_rc};
            cmd_reg <= {over ? PL_MAX : hnd_olen, 16'h0000};
            state_q <= S_FIN;
          end
        end
        S_FIN: begin
          doorbell <= 1'b0;
          state_q  <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  logic unused_rc;
  assign unused_rc = ^RC_BADIN;

endmodule

// File: rtl/mbox_dispatch_chk.sv
module mbox_dispatch_chk #(
  parameter int PAYLOAD_BYTES = 256
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_wr,
  input logic        db_set,
  input logic        doorbell,
  input logic [31:0] cmd_reg,
  input logic [15:0] sts_reg,
  input logic        hnd_start,
  input logic        hnd_done,
  input logic [15:0] hnd_olen,
  input logic [1:0]  state_q
);
  localparam logic [1:0]  ST_IDLE = 2'd0;
  localparam logic [1:0]  ST_BUSY = 2'd2;
  localparam logic [15:0] PL_MAX  = 16'(PAYLOAD_BYTES);

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    hnd_start |=> !hnd_start); // R10

  AST_START_WITH_DB: assert property (@(posedge clk) disable iff (!rst_n)
    hnd_start |-> doorbell); // R1

  AST_REGS_BEFORE_DB: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(doorbell) |-> ($stable(sts_reg) && $stable(cmd_reg))); // R7

  AST_FIELDS_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(doorbell) |-> (cmd_reg[15:0] == 16'h0000 && sts_reg[15:8] == 8'h00)); // R6

  AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (doorbell && cmd_wr && state_q == ST_BUSY) |=> $stable(cmd_reg)); // R8

  AST_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BUSY && hnd_done && hnd_olen > PL_MAX) |=>
      (sts_reg[7:0] == 8'h04 && cmd_reg[31:16] == PL_MAX)); // R9

  AST_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !cmd_wr && hnd_done) |=> ($stable(sts_reg) && $stable(cmd_reg))); // R10

  logic unused;
  assign unused = db_set;
endmodule

bind mbox_dispatch mbox_dispatch_chk #(.PAYLOAD_BYTES(PAYLOAD_BYTES)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .db_set(db_set),
  .doorbell(doorbell), .cmd_reg(cmd_reg), .sts_reg(sts_reg),
  .hnd_start(hnd_start), .hnd_done(hnd_done), .hnd_olen(hnd_olen),
  .state_q(state_q)
);

// File: tb/mbox_dispatch_tb_top.sv
module mbox_dispatch_tb_top;
  localparam int PL = 256;

  logic        clk = 0, rst_n = 0, cmd_wr = 0, db_set = 0;
  logic [31:0] cmd_wdata = '0;
  logic        doorbell, hnd_start;
  logic [31:0] cmd_reg;
  logic [15:0] sts_reg, hnd_op, hnd_len;
  logic        resp_done = 0, stray_done = 0, hnd_done;
  logic [7:0]  hnd_rc = 0, h_rc = 0;
  logic [15:0] hnd_olen = 0, h_olen = 0;
  logic        h_fixed = 0;
  int          h_delay = 2;
  int          checks = 0, fails = 0, starts = 0;
  logic [15:0] cap_op, cap_len;
  bit          finished = 0;

  assign hnd_done = resp_done | stray_done;
  always #5 clk = ~clk;

  mbox_dispatch #(.PAYLOAD_BYTES(PL)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .db_set(db_set), .doorbell(doorbell), .cmd_reg(cmd_reg), .sts_reg(sts_reg),
    .hnd_start(hnd_start), .hnd_op(hnd_op), .hnd_len(hnd_len),
    .hnd_done(hnd_done), .hnd_rc(hnd_rc), .hnd_olen(hnd_olen));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (hnd_start) begin
      starts++;
      cap_op  = hnd_op;
      cap_len = hnd_len;
      @(negedge clk);
      chk(!hnd_start, "R10 start pulse width", 32'(hnd_start), 32'd0);
      repeat (h_delay - 1) @(negedge clk);
      hnd_rc    = h_fixed ? h_rc   : 8'h00;
      hnd_olen  = h_fixed ? h_olen : 16'((cap_op[7:0] + cap_len[7:0]) & 8'hFF);
      resp_done = 1;
      @(negedge clk);
      resp_done = 0;
    end
  end

  function automatic void lookup(input logic [15:0] op, output bit known, output bit any, output logic [15:0] el);
    known = 1; any = 0; el = 0;
    case (op)
      16'h0100: el = 1;
      16'h0101, 16'h4103: any = 1;
      16'h0103: el = 4;
      16'h0301, 16'h4102: el = 8;
      16'h0401: el = 16'h18;
      16'h0102, 16'h0200, 16'h0300, 16'h0400, 16'h4000, 16'h4100: el = 0;
      default: known = 0;
    endcase
  endfunction

  task automatic run_cmd(input logic [7:0] st, input logic [7:0] cm, input logic [15:0] ln,
                         output logic [15:0] sts_o, output logic [31:0] cmd_o, output bit order_ok);
    logic [15:0] prev_sts;
    logic [31:0] prev_cmd;
    int guard;
    @(negedge clk);
    cmd_wdata = {ln, st, cm}; cmd_wr = 1; db_set = 1;
    @(negedge clk);
    cmd_wr = 0; db_set = 0;
    prev_sts = sts_reg; prev_cmd = cmd_reg;
    guard = 0;
    while (doorbell && guard < 1000) begin
      prev_sts = sts_reg; prev_cmd = cmd_reg;
      @(negedge clk);
      guard++;
    end
    sts_o = sts_reg; cmd_o = cmd_reg;
    order_ok = (prev_sts == sts_reg) && (prev_cmd == cmd_reg) && !doorbell;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] s;
    logic [31:0] c;
    bit ord;
    logic [7:0] sets [12] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h3F, 8'h40, 8'h41, 8'h42, 8'h80, 8'hFF};
    logic [15:0] lens [6] = '{16'd0, 16'd1, 16'd4, 16'd8, 16'h18, 16'h1234};
    int st0;

    repeat (3) @(negedge clk);
    chk(doorbell == 0 && hnd_start == 0, "R11 reset ctl", {30'd0, doorbell, hnd_start}, 32'd0);
    chk(cmd_reg == 0 && sts_reg == 0, "R11 reset regs", cmd_reg ^ 32'(sts_reg), 32'd0);
    rst_n = 1;

    foreach (sets[i]) begin
      for (int cm = 0; cm < 8; cm++) begin
        foreach (lens[j]) begin
          bit kn, an;
          logic [15:0] el, op, eo;
          logic [7:0] erc;
          op = {sets[i], 8'(cm)};
          lookup(op, kn, an, el);
          st0 = starts;
          run_cmd(sets[i], 8'(cm), lens[j], s, c, ord);
          if (!kn) begin
            chk(s == 16'h0003, "R3 unsupported rc", 32'(s), 32'h3);
            chk(starts == st0, "R3 no start", starts, st0);
            chk(c == {lens[j], 16'h0}, "R6 rejected cmd word", c, {lens[j], 16'h0});
          end else if (!an && lens[j] != el) begin
            chk(s == 16'h0016, "R4 length mismatch rc", 32'(s), 32'h16);
            chk(starts == st0, "R4 no start", starts, st0);
            chk(c == {lens[j], 16'h0}, "R6 rejected cmd word", c, {lens[j], 16'h0});
          end else begin
            erc = 8'h00;
            eo = 16'((op[7:0] + lens[j][7:0]) & 8'hFF);
            chk(starts == st0 + 1, an ? "R5 any-length start" : "R2 table start", starts, st0 + 1);
            chk(cap_op == op && cap_len == lens[j], "R1 handler op/len", {cap_op, cap_len}, {op, lens[j]});
            chk(s == {8'h00, erc}, "R6 status", 32'(s), 32'(erc));
            chk(c == {eo, 16'h0}, "R6 cmd word", c, {eo, 16'h0});
          end
          chk(ord, "R7 regs settle before doorbell drop", 32'(ord), 32'd1);
        end
      end
    end

    h_fixed = 1;
    h_rc = 8'h02; h_olen = 16'd12;
    run_cmd(8'h41, 8'h02, 16'd8, s, c, ord);
    chk(s == 16'h0002 && c == {16'd12, 16'h0}, "R6 rc passthrough", {s, c[31:16]}, {16'h2, 16'd12});

    h_rc = 8'h00; h_olen = 16'(PL + 5);
    run_cmd(8'h01, 8'h01, 16'd40, s, c, ord);
    chk(s == 16'h0004, "R9 clamp rc", 32'(s), 32'h4);
    chk(c[31:16] == 16'(PL), "R9 clamp len", 32'(c[31:16]), PL);

    h_olen = 16'(PL);
    run_cmd(8'h01, 8'h01, 16'd40, s, c, ord);
    chk(s == 16'h0000 && c[31:16] == 16'(PL), "R9 exact limit", {s, c[31:16]}, {16'h0, 16'(PL)});

    h_delay = 10; h_olen = 16'd7;
    st0 = starts;
    @(negedge clk);
    cmd_wdata = {16'd0, 8'h40, 8'h00}; cmd_wr = 1; db_set = 1;
    @(negedge clk);
    cmd_wr = 0; db_set = 0;
    repeat (3) @(negedge clk);
    cmd_wdata = {16'd9, 8'h03, 8'h01}; cmd_wr = 1; db_set = 1;
    @(negedge clk);
    cmd_wr = 0; db_set = 0;
    chk(cmd_reg == {16'd0, 8'h40, 8'h00}, "R8 write ignored", cmd_reg, {16'd0, 8'h40, 8'h00});
    while (doorbell) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(starts == st0 + 1, "R8 single start", starts, st0 + 1);
    chk(cmd_reg == {16'd7, 16'h0} && !doorbell, "R8 original completes", cmd_reg, {16'd7, 16'h0});

    @(negedge clk);
    stray_done = 1; hnd_rc = 8'h05; hnd_olen = 16'd99;
    @(negedge clk);
    stray_done = 0;
    @(negedge clk);
    chk(sts_reg == 16'h0000 && cmd_reg == {16'd7, 16'h0}, "R10 stray done ignored",
        {sts_reg, cmd_reg[31:16]}, {16'h0, 16'd7});

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule